// File: doc/BRIEF.md
# Exception and Special-Register Unit

This unit holds the supervisor-only special registers of a simple 32-bit processor and decides, cycle by cycle, whether the instruction in the execute stage ends in an exception. The pipeline presents the current instruction's PC, a set of per-instruction fault flags, the offending memory address and two external interrupt lines. When a cause passes its enable gate, the unit flags `exc_take` in the same cycle and asks fetch to restart at a fixed handler address. On the next clock edge it records the PC, a cause bitmask and, for a bad memory access, the address. It also switches the machine to privileged mode.

Move-to and move-from special register instructions reach the registers through a small access port, which works only in privileged mode. In user mode such an access, or a return-from-exception, becomes a privilege violation. A return-from-exception issued in privileged mode sends fetch back to the saved PC and drops the machine into user mode. Flushing the pipeline and the handler code are left to the surrounding core.

Top module: `exc_sreg_unit`

## Requirements
- R1: After reset the mode register (special register 0) reads 1, meaning privileged. Special registers 1 to 6 read 0, so every maskable cause starts out disabled. `exc_take` is low while no cause is raised.
- R2: In privileged mode, a write pulse (`spr_wr_en`) stores `spr_wdata` into special register `spr_addr` at the clock edge. Register 0 keeps only bit 0. Registers 2 and 4 keep bits 6:0. Registers 1, 3, 5 and 6 keep all 32 bits. A read (`spr_rd_en`) returns the stored value zero-extended on `spr_rdata` in the same cycle. `spr_rdata` is 0 when no privileged read is made.
- R3: When any enabled cause is present, `exc_take` and `redirect_valid` are high in that cycle and `redirect_pc` equals the parameter `HANDLER_VEC`. After the clock edge, special register 0 is 1 and special register 1 holds `instr_pc`.
- R4: On a taken exception, special register 2 is loaded with the taken causes as a bitmask: bit 0 overflow, bit 1 system call, bit 2 invalid instruction, bit 3 invalid memory reference, bit 4 privilege violation, bit 5 serial interrupt, bit 6 timer interrupt. Special register 3 is loaded with `badmem_addr` only when bit 3 is taken; otherwise it keeps its value.
- R5: Overflow (bit 0), the serial interrupt (bit 5) and the timer interrupt (bit 6) are taken only when the bit at the same position of special register 4 is 1. Otherwise they raise neither `exc_take` nor a cause bit.
- R6: System call, invalid instruction, invalid memory reference and privilege violation are taken whatever special register 4 holds.
- R7: In user mode, a move-to, a move-from or a return-from-exception raises a privilege violation (cause bit 4). The access then writes nothing, `spr_rdata` stays 0, and the mode is not cleared.
- R8: Causes raised in the same cycle are all recorded together in special register 2.
- R9: A return-from-exception (`rfi_req`) in privileged mode with no exception taken sets `redirect_valid` and drives `redirect_pc` with special register 1 in that cycle. After the clock edge the mode register reads 0.
- R10: Special registers 7 to 31 read as 0, and writes to them change nothing.
- R11: A taken exception overrides a move-to or return-from-exception in the same cycle. The write is dropped, the mode stays 1 and `redirect_pc` is `HANDLER_VEC`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spr_wr_en | input | 1 | Move-to special register in execute |
| spr_rd_en | input | 1 | Move-from special register in execute |
| spr_addr | input | 5 | Special register number |
| spr_wdata | input | 32 | Data for a move-to |
| spr_rdata | output | 32 | Data for a move-from, 0 when not a privileged read |
| instr_pc | input | 32 | PC of the instruction in execute |
| ev_ovf | input | 1 | Arithmetic overflow |
| ev_sys | input | 1 | System call |
| ev_illegal | input | 1 | Invalid instruction |
| ev_badmem | input | 1 | Invalid memory reference |
| badmem_addr | input | 32 | Address of the invalid reference |
| irq_serial | input | 1 | Serial port interrupt |
| irq_timer | input | 1 | Timer interrupt |
| rfi_req | input | 1 | Return-from-exception in execute |
| priv_mode | output | 1 | 1 while privileged |
| exc_take | output | 1 | An exception is taken this cycle |
| redirect_valid | output | 1 | Fetch must restart at `redirect_pc` |
| redirect_pc | output | 32 | Handler vector or saved PC |

## Verification
The hardest situations to reach from the ports are the collisions: an instruction-level event that coincides with a move-to, with a return-from-exception, or with several other causes in one cycle. The bench reaches user mode only through a genuine return-from-exception. It then issues special-register accesses there and, after the resulting privilege violation, reads the register back to show it was untouched. Collision cases drive a write or return together with a system call in one cycle. The restored register contents then show that the exception won.

// File: rtl/exc_pkg.sv
package exc_pkg;
   localparam int CAUSE_N   = 7;
   localparam int C_OVF     = 0;
   localparam int C_SYS     = 1;
   localparam int C_ILLEGAL = 2;
   localparam int C_BADMEM  = 3;
   localparam int C_PRIV    = 4;
   localparam int C_SERIAL  = 5;
   localparam int C_TIMER   = 6;

   localparam int SR_MODE  = 0;
   localparam int SR_EPC   = 1;
   localparam int SR_CAUSE = 2;
   localparam int SR_MEA   = 3;
   localparam int SR_MASK  = 4;
   localparam int SR_BASE  = 5;
   localparam int SR_BMASK = 6;
   localparam int SR_IMPL  = 7;

   typedef logic [CAUSE_N-1:0] cause_vec_t;
endpackage

// File: rtl/exc_cause_gate.sv
module exc_cause_gate
   import exc_pkg::*;
#(
   parameter cause_vec_t MASKABLE = 7'b110_0001
) (
   input  logic       clk,
   input  logic       rst_n,
   input  cause_vec_t raw,
   input  cause_vec_t enable,
   output cause_vec_t taken,
   output logic       take
);
   for (genvar i = 0; i < CAUSE_N; i++) begin : g_bit
      if (MASKABLE[i]) begin : g_gated
         assign taken[i] = raw[i] & enable[i];
      end else begin : g_free
         assign taken[i] = raw[i];
      end
   end

   assign take = |taken;

   // R5: a maskable cause whose enable bit is clear, alone, is never taken
   a_r5_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ((raw & ~MASKABLE) == '0 && (raw & enable) == '0) |-> !take);

   // R6: any non-maskable cause is always taken
   a_r6_forced_take: assert property (@(posedge clk) disable iff (!rst_n)
      ((raw & ~MASKABLE) != '0) |-> take);
endmodule

// File: rtl/exc_sreg_file.sv
module exc_sreg_file
   import exc_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int SPR_AW = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ok,
   input  logic [SPR_AW-1:0] addr,
   input  logic [XLEN-1:0]   wdata,
   input  logic              take,
   input  cause_vec_t        taken,
   input  logic [XLEN-1:0]   instr_pc,
   input  logic [XLEN-1:0]   badmem_addr,
   input  logic              rfi_commit,
   output logic              mode,
   output logic [XLEN-1:0]   epc,
   output cause_vec_t        enable,
   output logic [XLEN-1:0]   rd_mux
);
   cause_vec_t      cause_q;
   logic [XLEN-1:0] mea_q;
   logic [XLEN-1:0] base_q;
   logic [XLEN-1:0] bmask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode    <= 1'b1;
         epc     <= '0;
         cause_q <= '0;
         mea_q   <= '0;
         enable  <= '0;
         base_q  <= '0;
         bmask_q <= '0;
      end else if (take) begin
         mode    <= 1'b1;
         epc     <= instr_pc;
         cause_q <= taken;
         if (taken[C_BADMEM]) mea_q <= badmem_addr;
      end else begin
         if (rfi_commit) mode <= 1'b0;
         if (wr_ok) begin
            case (int'(addr))
               SR_MODE:  mode    <= wdata[0];
               SR_EPC:   epc     <= wdata;
               SR_CAUSE: cause_q <= wdata[CAUSE_N-1:0];
               SR_MEA:   mea_q   <= wdata;
               SR_MASK:  enable  <= wdata[CAUSE_N-1:0];
               SR_BASE:  base_q  <= wdata;
               SR_BMASK: bmask_q <= wdata;
               default:  ;
            endcase
         end
      end
   end

   always_comb begin
      case (int'(addr))
         SR_MODE:  rd_mux = XLEN'(mode);
         SR_EPC:   rd_mux = epc;
         SR_CAUSE: rd_mux = XLEN'(cause_q);
         SR_MEA:   rd_mux = mea_q;
         SR_MASK:  rd_mux = XLEN'(enable);
         SR_BASE:  rd_mux = base_q;
         SR_BMASK: rd_mux = bmask_q;
         default:  rd_mux = '0;
      endcase
   end

   // R3: entry forces privileged mode and saves the faulting PC
   a_r3_mode_set: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> mode);
   a_r3_epc_saved: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> epc == $past(instr_pc));
   // R4: bad address captured only with its cause
   a_r4_mea_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (take && taken[C_BADMEM]) |=> mea_q == $past(badmem_addr));
   // R8: recorded causes equal the taken set
   a_r8_cause_set: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> cause_q == $past(taken));
   // R9: a committed return drops to user mode
   a_r9_rfi_user: assert property (@(posedge clk) disable iff (!rst_n)
      (rfi_commit && !take) |=> !mode);
endmodule

// File: rtl/exc_sreg_unit.sv
module exc_sreg_unit
   import exc_pkg::*;
#(
   parameter int          XLEN        = 32,
   parameter int          SPR_COUNT   = 32,
   parameter logic [31:0] HANDLER_VEC = 32'h0000_0080,
   parameter cause_vec_t  MASKABLE    = 7'b110_0001,
   localparam int         SPR_AW      = $clog2(SPR_COUNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spr_wr_en,
   input  logic              spr_rd_en,
   input  logic [SPR_AW-1:0] spr_addr,
   input  logic [XLEN-1:0]   spr_wdata,
   output logic [XLEN-1:0]   spr_rdata,
   input  logic [XLEN-1:0]   instr_pc,
   input  logic              ev_ovf,
   input  logic              ev_sys,
   input  logic              ev_illegal,
   input  logic              ev_badmem,
   input  logic [XLEN-1:0]   badmem_addr,
   input  logic              irq_serial,
   input  logic              irq_timer,
   input  logic              rfi_req,
   output logic              priv_mode,
   output logic              exc_take,
   output logic              redirect_valid,
   output logic [XLEN-1:0]   redirect_pc
);
   if (SPR_COUNT < SR_IMPL + 1 || (1 << SPR_AW) != SPR_COUNT) begin : g_bad_count
      $error("SPR_COUNT must be a power of two holding all implemented registers");
   end
   if (XLEN < 32) begin : g_bad_xlen
      $error("XLEN must be at least 32");
   end

   logic            mode;
   logic [XLEN-1:0] epc;
   logic [XLEN-1:0] rd_mux;
   cause_vec_t      enable;
   cause_vec_t      raw;
   cause_vec_t      taken;
   logic            take;
   logic            user_trap;
   logic            wr_ok;
   logic            rfi_commit;

   assign user_trap = !mode && (spr_wr_en || spr_rd_en || rfi_req);

   always_comb begin
      raw            = '0;
      raw[C_OVF]     = ev_ovf;
      raw[C_SYS]     = ev_sys;
      raw[C_ILLEGAL] = ev_illegal;
      raw[C_BADMEM]  = ev_badmem;
      raw[C_PRIV]    = user_trap;
      raw[C_SERIAL]  = irq_serial;
      raw[C_TIMER]   = irq_timer;
   end

   exc_cause_gate #(.MASKABLE(MASKABLE)) gate_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw    (raw),
      .enable (enable),
      .taken  (taken),
      .take   (take)
   );

   assign wr_ok      = spr_wr_en && mode && !take;
   assign rfi_commit = rfi_req && mode && !take;

   exc_sreg_file #(.XLEN(XLEN), .SPR_AW(SPR_AW)) regs_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_ok       (wr_ok),
      .addr        (spr_addr),
      .wdata       (spr_wdata),
      .take        (take),
      .taken       (taken),
      .instr_pc    (instr_pc),
      .badmem_addr (badmem_addr),
      .rfi_commit  (rfi_commit),
      .mode        (mode),
      .epc         (epc),
      .enable      (enable),
      .rd_mux      (rd_mux)
   );

   assign spr_rdata      = (spr_rd_en && mode) ? rd_mux : '0;
   assign priv_mode      = mode;
   assign exc_take       = take;
   assign redirect_valid = take || rfi_commit;
   assign redirect_pc    = take ? XLEN'(HANDLER_VEC) : epc;

   // R7: user-mode special access always traps
   a_r7_user_trap: assert property (@(posedge clk) disable iff (!rst_n)
      (!priv_mode && (spr_wr_en || spr_rd_en || rfi_req)) |-> exc_take);
   // R7: user-mode access never returns data
   a_r7_no_user_data: assert property (@(posedge clk) disable iff (!rst_n)
      !priv_mode |-> spr_rdata == '0);
   // R11: an exception keeps the machine privileged even with a return present
   a_r11_exc_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_take && rfi_req) |=> priv_mode);
endmodule

// File: tb/exc_sreg_unit_tb.sv
module exc_sreg_unit_tb_top;
   localparam logic [31:0] VEC = 32'h0000_0080;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        spr_wr_en = 0, spr_rd_en = 0;
   logic [4:0]  spr_addr = '0;
   logic [31:0] spr_wdata = '0;
   logic [31:0] spr_rdata;
   logic [31:0] instr_pc = '0;
   logic        ev_ovf = 0, ev_sys = 0, ev_illegal = 0, ev_badmem = 0;
   logic [31:0] badmem_addr = '0;
   logic        irq_serial = 0, irq_timer = 0, rfi_req = 0;
   logic        priv_mode, exc_take, redirect_valid;
   logic [31:0] redirect_pc;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   exc_sreg_unit #(.HANDLER_VEC(VEC)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .spr_wr_en(spr_wr_en), .spr_rd_en(spr_rd_en), .spr_addr(spr_addr),
      .spr_wdata(spr_wdata), .spr_rdata(spr_rdata), .instr_pc(instr_pc),
      .ev_ovf(ev_ovf), .ev_sys(ev_sys), .ev_illegal(ev_illegal),
      .ev_badmem(ev_badmem), .badmem_addr(badmem_addr),
      .irq_serial(irq_serial), .irq_timer(irq_timer), .rfi_req(rfi_req),
      .priv_mode(priv_mode), .exc_take(exc_take),
      .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic clear_inputs();
      spr_wr_en = 0; spr_rd_en = 0; rfi_req = 0;
      ev_ovf = 0; ev_sys = 0; ev_illegal = 0; ev_badmem = 0;
      irq_serial = 0; irq_timer = 0;
   endtask

   task automatic spr_write(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      spr_wr_en = 1; spr_addr = a; spr_wdata = d;
      @(posedge clk); #1;
      spr_wr_en = 0;
   endtask

   task automatic spr_read(input logic [4:0] a, output logic [31:0] v);
      @(negedge clk);
      spr_rd_en = 1; spr_addr = a;
      #1 v = spr_rdata;
      spr_rd_en = 0;
   endtask

   // apply events set by caller at a negedge, sample, then commit at posedge
   task automatic commit_cycle();
      @(posedge clk); #1;
      clear_inputs();
   endtask

   task automatic t_reset();
      logic [31:0] v;
      check("R1 mode after reset", 32'(priv_mode), 32'd1);
      check("R1 no take after reset", 32'(exc_take), 32'd0);
      spr_read(5'd4, v); check("R1 mask after reset", v, 32'd0);
      spr_read(5'd1, v); check("R1 epc after reset", v, 32'd0);
      spr_read(5'd2, v); check("R1 cause after reset", v, 32'd0);
   endtask

   task automatic t_access();
      logic [31:0] v;
      spr_write(5'd5, 32'hDEAD_BEEF);
      spr_read(5'd5, v); check("R2 base reg readback", v, 32'hDEAD_BEEF);
      spr_write(5'd6, 32'h00FF_F000);
      spr_read(5'd6, v); check("R2 bmask reg readback", v, 32'h00FF_F000);
      spr_write(5'd0, 32'hFFFF_FFFF);
      spr_read(5'd0, v); check("R2 mode keeps bit0", v, 32'd1);
      spr_write(5'd4, 32'hFFFF_FFFF);
      spr_read(5'd4, v); check("R2 mask keeps 7 bits", v, 32'h7F);
      spr_write(5'd4, 32'd0);
      @(negedge clk);
      spr_addr = 5'd5;
      #1 check("R2 rdata zero without read", spr_rdata, 32'd0);
      spr_write(5'd9, 32'h1234_5678);
      spr_read(5'd9, v); check("R10 reg9 reads zero", v, 32'd0);
      spr_read(5'd31, v); check("R10 reg31 reads zero", v, 32'd0);
      spr_read(5'd5, v); check("R10 write to reg9 left reg5", v, 32'hDEAD_BEEF);
   endtask

   task automatic t_syscall();
      logic [31:0] v;
      @(negedge clk);
      instr_pc = 32'h0000_0400; ev_sys = 1;
      #1;
      check("R3 take on syscall", 32'(exc_take), 32'd1);
      check("R3 redirect valid", 32'(redirect_valid), 32'd1);
      check("R3 redirect to vector", redirect_pc, VEC);
      commit_cycle();
      check("R3 mode after entry", 32'(priv_mode), 32'd1);
      spr_read(5'd1, v); check("R3 epc saved", v, 32'h0000_0400);
      spr_read(5'd2, v); check("R4 syscall cause", v, 32'h2);
   endtask

   task automatic t_mask();
      logic [31:0] v;
      @(negedge clk); ev_ovf = 1;
      #1 check("R5 masked overflow ignored", 32'(exc_take), 32'd0);
      commit_cycle();
      @(negedge clk); irq_timer = 1; irq_serial = 1;
      #1 check("R5 masked interrupts ignored", 32'(exc_take), 32'd0);
      commit_cycle();
      spr_read(5'd2, v); check("R5 cause unchanged when masked", v, 32'h2);
      spr_write(5'd4, 32'h01);
      @(negedge clk); ev_ovf = 1; instr_pc = 32'h0000_0500;
      #1 check("R5 enabled overflow taken", 32'(exc_take), 32'd1);
      commit_cycle();
      spr_read(5'd2, v); check("R5 overflow cause", v, 32'h1);
   endtask

   task automatic t_nonmask();
      logic [31:0] v;
      spr_write(5'd4, 32'd0);
      @(negedge clk); ev_illegal = 1;
      #1 check("R6 illegal taken with mask 0", 32'(exc_take), 32'd1);
      commit_cycle();
      spr_read(5'd2, v); check("R6 illegal cause", v, 32'h4);
      @(negedge clk); ev_badmem = 1; badmem_addr = 32'h00AB_CDE0;
      #1 check("R6 badmem taken with mask 0", 32'(exc_take), 32'd1);
      commit_cycle();
      spr_read(5'd3, v); check("R4 bad address captured", v, 32'h00AB_CDE0);
      spr_read(5'd2, v); check("R4 badmem cause", v, 32'h8);
      @(negedge clk); ev_sys = 1; badmem_addr = 32'h1111_1111;
      commit_cycle();
      spr_read(5'd3, v); check("R4 address held without badmem", v, 32'h00AB_CDE0);
   endtask

   task automatic t_coincide();
      logic [31:0] v;
      spr_write(5'd4, 32'h60);
      @(negedge clk); ev_illegal = 1; irq_timer = 1; irq_serial = 1;
      instr_pc = 32'h0000_0600;
      commit_cycle();
      spr_read(5'd2, v); check("R8 combined causes", v, 32'h64);
      spr_read(5'd1, v); check("R8 epc with combined causes", v, 32'h0000_0600);
   endtask

   task automatic t_priority();
      logic [31:0] v;
      spr_write(5'd5, 32'h55);
      @(negedge clk);
      spr_wr_en = 1; spr_addr = 5'd5; spr_wdata = 32'hAA; ev_sys = 1;
      commit_cycle();
      spr_read(5'd5, v); check("R11 write dropped on exception", v, 32'h55);
      @(negedge clk);
      rfi_req = 1; ev_sys = 1; instr_pc = 32'h0000_0700;
      #1 check("R11 vector beats return", redirect_pc, VEC);
      commit_cycle();
      check("R11 mode stays privileged", 32'(priv_mode), 32'd1);
   endtask

   task automatic t_rfi();
      @(negedge clk); rfi_req = 1;
      #1;
      check("R9 return redirect valid", 32'(redirect_valid), 32'd1);
      check("R9 return to saved pc", redirect_pc, 32'h0000_0700);
      check("R9 return not an exception", 32'(exc_take), 32'd0);
      commit_cycle();
      check("R9 user mode after return", 32'(priv_mode), 32'd0);
   endtask

   task automatic t_user();
      logic [31:0] v;
      spr_read(5'd5, v); check("R7 user read gives zero", v, 32'd0);
      @(negedge clk);
      spr_wr_en = 1; spr_addr = 5'd5; spr_wdata = 32'hAA; instr_pc = 32'h0000_0800;
      #1 check("R7 user write traps", 32'(exc_take), 32'd1);
      commit_cycle();
      check("R7 privileged after trap", 32'(priv_mode), 32'd1);
      spr_read(5'd2, v); check("R7 privilege cause", v, 32'h10);
      spr_read(5'd5, v); check("R7 user write dropped", v, 32'h55);
      @(negedge clk); rfi_req = 1;
      commit_cycle();
      @(negedge clk); rfi_req = 1;
      #1;
      check("R7 user return traps", 32'(exc_take), 32'd1);
      check("R7 user return goes to vector", redirect_pc, VEC);
      commit_cycle();
      check("R7 mode set by user return trap", 32'(priv_mode), 32'd1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;
      t_reset();
      t_access();
      t_syscall();
      t_mask();
      t_nonmask();
      t_coincide();
      t_priority();
      t_rfi();
      t_user();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end
endmodule